// File: doc/BRIEF.md
# Double-Buffered Converter Code Latch

This block is the clocked digital front end of an 8-bit voltage-output converter. A host drives a data bus and four active-low strobes: a chip select, a write strobe, a load strobe and a clear. The block holds two code registers in series. The first stage (staging register) takes the bus under chip select and write. The second stage (output register) takes the staging contents under load and write. Only the output register reaches the converter code output. Because the second stage has its own load strobe, many converters can be staged one by one and then switched together.

All strobes and the bus are asynchronous to the block clock. They pass through a two-flop synchronizer before use. Each stage copies the bus on every clock while its strobes hold it open, which models a level-sensitive latch. When the synchronized write strobe rises, the stage closes and keeps the last value it took. Each stage is a small state machine with three named modes. ZERO is selected while the clear is active. LOAD is selected while the stage is open. HOLD applies otherwise. The mode is chosen again on every clock, so the transitions are HOLD→LOAD when the stage opens, LOAD→HOLD when write rises, any→ZERO when the clear goes low, and ZERO→LOAD or ZERO→HOLD when it is released.

Top module: `dac_dbl_latch`

## Requirements
- R1: After the system reset `rst_n` is released, `code_out` is 0 and the staging register holds 0.
- R2: While `cs_n` and `wr_n` are both low, the staging register takes `din` on every clock. It keeps the last value sampled with `wr_n` low.
- R3: While `ldac_n` and `wr_n` are both low, the output register takes the staging register contents.
- R4: Loading the staging register while `ldac_n` is high leaves `code_out` unchanged.
- R5: While `cs_n`, `wr_n` and `ldac_n` are all low, `code_out` follows `din`, including the codes 8'h00 and 8'hFF.
- R6: With both stages open, a low `clr_n` holds `code_out` at 0. After `clr_n` returns high, `code_out` follows `din` again.
- R7: With both stages closed, a low pulse on `clr_n` leaves 0 in both registers. `code_out` stays 0 after release, and a later transfer through the load strobe still gives 0.
- R8: While `wr_n` is high, or while `cs_n` and `ldac_n` are both high, both registers keep their contents.
- R9: A change on any input pin reaches `code_out` exactly three clocks after it is sampled: two synchronizer flops plus the register.
- R10: Data that changes in the same cycle that `wr_n` rises is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| cs_n | input | 1 | Chip select for the staging register, active low |
| wr_n | input | 1 | Write strobe shared by both stages, active low |
| ldac_n | input | 1 | Load strobe for the output register, active low |
| clr_n | input | 1 | Clear of both registers, active low |
| din | input | DATA_W | Code bus |
| code_out | output | DATA_W | Output register contents, i.e. the converter code |

## Verification
The bench builds the block with its defaults: an 8-bit code and two synchronizer stages. With 8 bits, both end codes 8'h00 and 8'hFF can be driven on the bus. The two-stage setting gives a fixed three-cycle path, so the bench can check the exact cycle in which a bus change appears at the output. A behavioural model keeps a delay queue of pin snapshots and predicts `code_out` on every clock. Directed checks with constant expected values cover capture at the rising write strobe, the clear acting as an override versus a persistent load, and the hold conditions.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

    // Operating mode of one latch stage, re-selected every clock
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOAD = 2'd1,
        ST_ZERO = 2'd2
    } stage_mode_e;

    // Number of control strobes carried next to the data bus
    localparam int unsigned CTL_PINS = 4;

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= INIT;
                else        chain[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= INIT;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/dac_latch_stage.sv
module dac_latch_stage
    import dac_latch_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    stage_mode_e mode;
    logic [DATA_W-1:0] q_r;

    // Mode selection: clear wins over transparency
    always_comb begin
        if (clr_i)       mode = ST_ZERO;
        else if (open_i) mode = ST_LOAD;
        else             mode = ST_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            unique case (mode)
                ST_ZERO: q_r <= '0;
                ST_LOAD: q_r <= d_i;
                ST_HOLD: q_r <= q_r;
                default: q_r <= q_r;
            endcase
        end
    end

    assign q_o = q_r;

    AST_STAGE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && !clr_i) |=> (q_o == $past(d_i))); // R2
    AST_STAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q_o == '0)); // R7
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_i && !clr_i) |=> $stable(q_o)); // R8

endmodule

// File: rtl/dac_dbl_latch.sv
module dac_dbl_latch
    import dac_latch_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] code_out
);

    localparam int unsigned PIN_W = DATA_W + CTL_PINS;
    localparam logic [PIN_W-1:0] PIN_IDLE = {{CTL_PINS{1'b1}}, {DATA_W{1'b0}}};

    logic [PIN_W-1:0]  pins_s;
    logic [DATA_W-1:0] data_s;
    logic cs_s, wr_s, ldac_s, clr_s;
    logic in_open, out_open;
    logic [DATA_W-1:0] stage_q, out_q, out_d;

    dac_pin_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .INIT   (PIN_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({clr_n, ldac_n, wr_n, cs_n, din}),
        .sync_out (pins_s)
    );

    assign {clr_s, ldac_s, wr_s, cs_s, data_s} = pins_s;

    assign in_open  = !cs_s   && !wr_s;
    assign out_open = !ldac_s && !wr_s;

    // With both stages open the bus passes straight through both latches
    assign out_d = in_open ? data_s : stage_q;

    dac_latch_stage #(.DATA_W(DATA_W)) u_stage_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (in_open),
        .clr_i  (!clr_s),
        .d_i    (data_s),
        .q_o    (stage_q)
    );

    dac_latch_stage #(.DATA_W(DATA_W)) u_stage_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (out_open),
        .clr_i  (!clr_s),
        .d_i    (out_d),
        .q_o    (out_q)
    );

    assign code_out = out_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (code_out == '0)); // R6
    AST_FOLLOW_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !cs_s && !wr_s && !ldac_s) |=> (code_out == $past(data_s))); // R5
    AST_XFER_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && cs_s && !wr_s && !ldac_s) |=> (code_out == $past(stage_q))); // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && wr_s) |=> ($stable(code_out) && $stable(stage_q))); // R8
    AST_OUT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && ldac_s) |=> $stable(code_out)); // R4

endmodule

// File: tb/dac_dbl_latch_bench.sv
module dac_dbl_latch_bench;

    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] code_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dac_dbl_latch u_dac_dbl_latch (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .ldac_n(ldac_n), .clr_n(clr_n), .din(din), .code_out(code_out)
    );

    // Behavioural reference: delay queue of pin snapshots, then two latches
    logic [DW+3:0] hist [$];
    logic [DW-1:0] m_stage, m_out;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = {};
            m_stage = '0;
            m_out = '0;
        end else begin
            hist.push_back({clr_n, ldac_n, wr_n, cs_n, din});
            if (hist.size() > 2) begin
                logic [DW+3:0] p;
                logic [DW-1:0] d;
                logic s_open, o_open, c_act;
                p = hist.pop_front();
                d = p[DW-1:0];
                c_act  = !p[DW+3];
                s_open = !p[DW] && !p[DW+1];
                o_open = !p[DW+2] && !p[DW+1];
                if (c_act) begin
                    m_stage = '0;
                    m_out = '0;
                end else begin
                    if (o_open) m_out = s_open ? d : m_stage;
                    if (s_open) m_stage = d;
                end
            end
        end
    end

    task automatic check(string tag, logic [DW-1:0] exp);
        checks++;
        if (code_out !== exp) begin
            fails++;
            $display("FAIL %s code_out=%02h expected=%02h at %0t", tag, code_out, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model (cycle-exact path, R9)
    always @(negedge clk) begin
        if (rst_n && !done) check("R9_model", m_out);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(logic c, logic w, logic l, logic r, logic [DW-1:0] d);
        cs_n = c; wr_n = w; ldac_n = l; clr_n = r; din = d;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1", 8'h00);

        // R2 / R4 / R10: load staging only; data changes with WR rise
        pins(0, 0, 1, 1, 8'hA5); cyc(3);
        pins(0, 0, 1, 1, 8'h3C); cyc(1);
        pins(0, 1, 1, 1, 8'hFF); cyc(4);
        check("R4", 8'h00);
        pins(1, 1, 1, 1, 8'h00); cyc(1);

        // R3: transfer staging to output
        pins(1, 0, 0, 1, 8'h00); cyc(2);
        pins(1, 1, 1, 1, 8'h00); cyc(4);
        check("R3", 8'h3C);
        check("R2", 8'h3C);
        check("R10", 8'h3C);

        // R8: write with both selects high; then selects low with WR high
        pins(1, 0, 1, 1, 8'h77); cyc(4);
        pins(0, 1, 0, 1, 8'h11); cyc(4);
        check("R8", 8'h3C);

        // R5 / R9: both open, follow bus, exact latency
        pins(0, 0, 0, 1, 8'h12); cyc(4);
        check("R5", 8'h12);
        pins(0, 0, 0, 1, 8'h9A); cyc(2);
        check("R9", 8'h12);
        cyc(1);
        check("R9", 8'h9A);
        pins(0, 0, 0, 1, 8'hFF); cyc(4);
        check("R5", 8'hFF);
        pins(0, 0, 0, 1, 8'h00); cyc(4);
        check("R5", 8'h00);
        pins(0, 0, 0, 1, 8'h9A); cyc(4);

        // R6: zero override while open
        pins(0, 0, 0, 0, 8'h9A); cyc(4);
        check("R6", 8'h00);
        pins(0, 0, 0, 1, 8'h9A); cyc(4);
        check("R6", 8'h9A);

        // R7: clear while latched persists
        pins(1, 1, 1, 1, 8'h9A); cyc(4);
        check("R8", 8'h9A);
        pins(1, 1, 1, 0, 8'h9A); cyc(3);
        pins(1, 1, 1, 1, 8'h9A); cyc(4);
        check("R7", 8'h00);
        pins(1, 0, 0, 1, 8'h55); cyc(3);
        pins(1, 1, 1, 1, 8'h55); cyc(4);
        check("R7", 8'h00);

        // R2 again with a new value, then transfer
        pins(0, 0, 1, 1, 8'hC3); cyc(3);
        pins(1, 1, 1, 1, 8'h00); cyc(2);
        pins(1, 0, 0, 1, 8'h00); cyc(2);
        pins(1, 1, 1, 1, 8'h00); cyc(4);
        check("R2", 8'hC3);

        finish_run();
    end

endmodule